// File: doc/BRIEF.md
# Four-Slot Masked Address Window Decoder

This block decides which of four expansion-slot memory windows, if any, a 32-bit processor address falls into. Each slot holds a 16-bit base value, an 8-bit size mask and an enable bit. The base is compared against the top sixteen address bits. A set bit in the size mask makes the matching base and address bit (among address bits 23..16) a don't-care, so every window sits on a boundary that is a multiple of its own size. The result is a one-hot select vector plus a summary hit flag, both combinational from the address and the stored registers.

A pairing mode lets slots a and b, and separately slots c and d, merge into one double-width window. A merged pair is decoded only through the first slot's registers and is reported on that slot's select bit. The second slot of a merged pair is ignored entirely. The pairing mode is held in a small state machine with four states: `PAIR_NONE` (all slots independent), `PAIR_AB` (a and b merged), `PAIR_CD` (c and d merged) and `PAIR_BOTH` (both pairs merged). There is one kind of transition: a write on the pairing port moves the machine from any state to the state named by its two request bits. With no write, it stays in its current state.

Software writes a whole slot (base, mask and enable) in one clock through the configuration port. Overlapping windows are resolved by a fixed priority, so the select vector never has more than one bit set.

Top module: `slot_window_decoder`

## Requirements
- R1: After reset every slot is disabled and the pairing mode is `PAIR_NONE`, so `sel` is 4'b0000 and `hit` is 0 for any address.
- R2: With an all-zero size mask, an enabled slot is selected exactly when `addr[31:16]` equals its base, which covers a 64 KiB window. Select bit index equals slot number: bit 0 is a, bit 1 is b, bit 2 is c, bit 3 is d. `cfg_slot` uses the same numbering.
- R3: Size mask bit k (k = 0..7) makes address bit 16+k and base bit k irrelevant to the comparison. For example, mask 0x01 gives 128 KiB windows and mask 0x03 gives 256 KiB windows, aligned to their size.
- R4: Address bits 31..24 are always compared against base bits 15..8, whatever the size mask holds.
- R5: A slot whose enable bit is 0 never asserts its select bit.
- R6: When several eligible slots match, only the lowest-numbered one is selected. `sel` is at most one-hot, and `hit` is 1 exactly when `sel` is nonzero.
- R7: In `PAIR_AB` and `PAIR_BOTH`, the registers of slot b are ignored: `sel[1]` never asserts, and the merged window follows slot a's registers on `sel[0]`.
- R8: In `PAIR_CD` and `PAIR_BOTH`, the registers of slot d are ignored: `sel[3]` never asserts, and the merged window follows slot c's registers on `sel[2]`.
- R9: Writes to `cfg_*` or `pair_*` take effect at the next rising clock edge. `sel` and `hit` follow `addr` combinationally within the same cycle.
- R10: Writing the pairing port with both request bits at 0 returns to `PAIR_NONE`, which restores the independent windows of slots b and d from their own registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for one slot's registers |
| cfg_slot | input | 2 | Slot written (0=a, 1=b, 2=c, 3=d) |
| cfg_base | input | 16 | Base value compared with addr[31:16] |
| cfg_size | input | 8 | Size mask; bit k ignores addr bit 16+k |
| cfg_enable | input | 1 | Slot enable |
| pair_wr | input | 1 | Write strobe for the pairing mode |
| pair_ab | input | 1 | Request merging of slots a and b |
| pair_cd | input | 1 | Request merging of slots c and d |
| addr | input | 32 | Processor address to decode |
| sel | output | 4 | One-hot slot select, bit n for slot n |
| hit | output | 1 | Some slot is selected |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 16-bit base and an 8-bit size mask. This leaves eight upper address bits that are never masked, so one test can set every mask bit and still show that a change in address bit 24 ends the match. With the full 8-bit mask range available, the 128 KiB and 256 KiB alignments, as well as a 16-fold window that overlaps a smaller one, can all be exercised. Every transition of the pairing state machine the brief names is driven, including the return to `PAIR_NONE` that brings back slots b and d.

// File: rtl/slot_window_pkg.sv
package slot_window_pkg;

    localparam int NUM_SLOTS = 4;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);

    // Pairing mode of the four slots.
    typedef enum logic [1:0] {
        PAIR_NONE = 2'b00,
        PAIR_AB   = 2'b01,
        PAIR_CD   = 2'b10,
        PAIR_BOTH = 2'b11
    } pair_mode_e;

endpackage

// File: rtl/swd_slot_regs.sv
module swd_slot_regs
    import slot_window_pkg::*;
#(
    parameter int BASE_W = 16,
    parameter int MASK_W = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_wr,
    input  logic [SLOT_W-1:0]                  cfg_slot,
    input  logic [BASE_W-1:0]                  cfg_base,
    input  logic [MASK_W-1:0]                  cfg_size,
    input  logic                               cfg_enable,
    output logic [NUM_SLOTS-1:0][BASE_W-1:0]   base_q,
    output logic [NUM_SLOTS-1:0][MASK_W-1:0]   size_q,
    output logic [NUM_SLOTS-1:0]               en_q
);

    // One register set per slot; a write loads base, mask and enable together.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[s] <= '0;
                size_q[s] <= '0;
                en_q[s]   <= 1'b0;
            end else if (cfg_wr && (cfg_slot == SLOT_W'(s))) begin
                base_q[s] <= cfg_base;
                size_q[s] <= cfg_size;
                en_q[s]   <= cfg_enable;
            end
        end
    end

endmodule

// File: rtl/swd_pair_fsm.sv
module swd_pair_fsm
    import slot_window_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pair_wr,
    input  logic                 pair_ab,
    input  logic                 pair_cd,
    output logic [NUM_SLOTS-1:0] inhibit
);

    pair_mode_e state_q, state_d;

    // Next-state selection: a write jumps to the requested mode.
    always_comb begin
        state_d = state_q;
        if (pair_wr) begin
            unique case ({pair_cd, pair_ab})
                2'b00: state_d = PAIR_NONE;
                2'b01: state_d = PAIR_AB;
                2'b10: state_d = PAIR_CD;
                2'b11: state_d = PAIR_BOTH;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PAIR_NONE;
        else        state_q <= state_d;
    end

    // Outputs: the second slot of each merged pair is inhibited.
    always_comb begin
        unique case (state_q)
            PAIR_NONE: inhibit = 4'b0000;
            PAIR_AB:   inhibit = 4'b0010;
            PAIR_CD:   inhibit = 4'b1000;
            PAIR_BOTH: inhibit = 4'b1010;
        endcase
    end

endmodule

// File: rtl/swd_match.sv
module swd_match
    import slot_window_pkg::*;
#(
    parameter int BASE_W = 16,
    parameter int MASK_W = 8
) (
    input  logic [BASE_W-1:0]                 addr_hi,
    input  logic [NUM_SLOTS-1:0][BASE_W-1:0]  base_q,
    input  logic [NUM_SLOTS-1:0][MASK_W-1:0]  size_q,
    input  logic [NUM_SLOTS-1:0]              en_q,
    output logic [NUM_SLOTS-1:0]              raw_hit
);

    localparam int FIX_W = BASE_W - MASK_W;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
        logic [BASE_W-1:0] care;
        logic [BASE_W-1:0] diff;
        // Upper FIX_W bits are always compared; lower ones drop out where masked.
        assign care       = {{FIX_W{1'b1}}, ~size_q[s]};
        assign diff       = (addr_hi ^ base_q[s]) & care;
        assign raw_hit[s] = en_q[s] && (diff == '0);
    end

endmodule

// File: rtl/swd_arbiter.sv
module swd_arbiter
    import slot_window_pkg::*;
(
    input  logic [NUM_SLOTS-1:0] raw_hit,
    input  logic [NUM_SLOTS-1:0] inhibit,
    output logic [NUM_SLOTS-1:0] sel
);

    logic [NUM_SLOTS-1:0] eligible;
    assign eligible = raw_hit & ~inhibit;

    // Fixed priority: lowest slot number wins.
    always_comb begin
        logic taken;
        taken = 1'b0;
        sel   = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (eligible[s] && !taken) begin
                sel[s] = 1'b1;
                taken  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/slot_window_decoder.sv
module slot_window_decoder
    import slot_window_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BASE_W = 16,
    parameter int MASK_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [SLOT_W-1:0]    cfg_slot,
    input  logic [BASE_W-1:0]    cfg_base,
    input  logic [MASK_W-1:0]    cfg_size,
    input  logic                 cfg_enable,
    input  logic                 pair_wr,
    input  logic                 pair_ab,
    input  logic                 pair_cd,
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_SLOTS-1:0] sel,
    output logic                 hit
);

    localparam int LSB = ADDR_W - BASE_W;

    logic [NUM_SLOTS-1:0][BASE_W-1:0] base_q;
    logic [NUM_SLOTS-1:0][MASK_W-1:0] size_q;
    logic [NUM_SLOTS-1:0]             en_q;
    logic [NUM_SLOTS-1:0]             inhibit;
    logic [NUM_SLOTS-1:0]             raw_hit;
    logic                             unused_low_addr;

    assign unused_low_addr = ^addr[LSB-1:0];

    swd_slot_regs #(.BASE_W(BASE_W), .MASK_W(MASK_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_slot   (cfg_slot),
        .cfg_base   (cfg_base),
        .cfg_size   (cfg_size),
        .cfg_enable (cfg_enable),
        .base_q     (base_q),
        .size_q     (size_q),
        .en_q       (en_q)
    );

    swd_pair_fsm u_pair (
        .clk     (clk),
        .rst_n   (rst_n),
        .pair_wr (pair_wr),
        .pair_ab (pair_ab),
        .pair_cd (pair_cd),
        .inhibit (inhibit)
    );

    swd_match #(.BASE_W(BASE_W), .MASK_W(MASK_W)) u_match (
        .addr_hi (addr[ADDR_W-1:LSB]),
        .base_q  (base_q),
        .size_q  (size_q),
        .en_q    (en_q),
        .raw_hit (raw_hit)
    );

    swd_arbiter u_arb (
        .raw_hit (raw_hit),
        .inhibit (inhibit),
        .sel     (sel)
    );

    assign hit = |sel;

endmodule

// File: rtl/slot_window_decoder_chk.sv
module slot_window_decoder_chk
    import slot_window_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BASE_W = 16,
    parameter int MASK_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_wr,
    input logic [SLOT_W-1:0]    cfg_slot,
    input logic [BASE_W-1:0]    cfg_base,
    input logic                 cfg_enable,
    input logic                 pair_wr,
    input logic                 pair_ab,
    input logic                 pair_cd,
    input logic [ADDR_W-1:0]    addr,
    input logic [NUM_SLOTS-1:0] sel
);

    localparam int FIX_W = BASE_W - MASK_W;

    // Shadow of what the configuration ports have written.
    logic [NUM_SLOTS-1:0][FIX_W-1:0] sh_top;
    logic [NUM_SLOTS-1:0]            sh_en;
    logic                            sh_ab;
    logic                            sh_cd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_top <= '0;
            sh_en  <= '0;
            sh_ab  <= 1'b0;
            sh_cd  <= 1'b0;
        end else begin
            if (cfg_wr) begin
                sh_top[cfg_slot] <= cfg_base[BASE_W-1 -: FIX_W];
                sh_en[cfg_slot]  <= cfg_enable;
            end
            if (pair_wr) begin
                sh_ab <= pair_ab;
                sh_cd <= pair_cd;
            end
        end
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel)); // R6

    AST_SEL_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (sel & ~sh_en) == '0); // R5

    AST_B_QUIET_MERGED: assert property (@(posedge clk) disable iff (!rst_n)
        sh_ab |-> !sel[1]); // R7

    AST_D_QUIET_MERGED: assert property (@(posedge clk) disable iff (!rst_n)
        sh_cd |-> !sel[3]); // R8

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_top
        AST_UPPER_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
            sel[s] |-> (addr[ADDR_W-1 -: FIX_W] == sh_top[s])); // R4
    end

endmodule

bind slot_window_decoder slot_window_decoder_chk #(
    .ADDR_W (ADDR_W),
    .BASE_W (BASE_W),
    .MASK_W (MASK_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_slot   (cfg_slot),
    .cfg_base   (cfg_base),
    .cfg_enable (cfg_enable),
    .pair_wr    (pair_wr),
    .pair_ab    (pair_ab),
    .pair_cd    (pair_cd),
    .addr       (addr),
    .sel        (sel)
);

// File: tb/slot_window_decoder_test.sv
module slot_window_decoder_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_slot = '0;
    logic [15:0] cfg_base = '0;
    logic [7:0]  cfg_size = '0;
    logic        cfg_enable = 1'b0;
    logic        pair_wr = 1'b0;
    logic        pair_ab = 1'b0;
    logic        pair_cd = 1'b0;
    logic [31:0] addr = '0;
    logic [3:0]  sel;
    logic        hit;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slot_window_decoder uut (
        .clk (clk), .rst_n (rst_n),
        .cfg_wr (cfg_wr), .cfg_slot (cfg_slot), .cfg_base (cfg_base),
        .cfg_size (cfg_size), .cfg_enable (cfg_enable),
        .pair_wr (pair_wr), .pair_ab (pair_ab), .pair_cd (pair_cd),
        .addr (addr), .sel (sel), .hit (hit)
    );

    task automatic check_sel(input logic [3:0] exp, input string req);
        n_checks++;
        if (sel !== exp || hit !== (exp != 4'b0)) begin
            n_fail++;
            $display("FAIL %s addr=%h sel=%b hit=%b expected sel=%b hit=%b",
                     req, addr, sel, hit, exp, exp != 4'b0);
        end
    endtask

    task automatic probe(input logic [31:0] a, input logic [3:0] exp, input string req);
        addr = a;
        #1;
        check_sel(exp, req);
    endtask

    task automatic write_slot(input logic [1:0] s, input logic [15:0] b,
                              input logic [7:0] m, input logic en);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_slot = s; cfg_base = b; cfg_size = m; cfg_enable = en;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic write_pair(input logic ab, input logic cd);
        @(negedge clk);
        pair_wr = 1'b1; pair_ab = ab; pair_cd = cd;
        @(negedge clk);
        pair_wr = 1'b0;
    endtask

    task automatic t_reset;
        probe(32'h0000_0000, 4'b0000, "R1");
        probe(32'h1234_5678, 4'b0000, "R1");
    endtask

    task automatic t_exact;
        write_slot(2'd0, 16'h0012, 8'h00, 1'b1);
        probe(32'h0012_0000, 4'b0001, "R2");
        probe(32'h0012_FFFF, 4'b0001, "R2");
        probe(32'h0013_0000, 4'b0000, "R2");
        probe(32'h0011_FFFF, 4'b0000, "R2");
    endtask

    task automatic t_mask;
        write_slot(2'd0, 16'h0012, 8'h00, 1'b0);
        write_slot(2'd1, 16'h0013, 8'h01, 1'b1);
        probe(32'h0012_0000, 4'b0010, "R3");
        probe(32'h0013_0004, 4'b0010, "R3");
        probe(32'h0014_0000, 4'b0000, "R3");
        write_slot(2'd1, 16'h0040, 8'h03, 1'b1);
        probe(32'h0040_0000, 4'b0010, "R3");
        probe(32'h0043_FFFF, 4'b0010, "R3");
        probe(32'h0044_0000, 4'b0000, "R3");
        probe(32'h003F_FFFF, 4'b0000, "R3");
    endtask

    task automatic t_upper;
        write_slot(2'd2, 16'h12FF, 8'hFF, 1'b1);
        probe(32'h1200_0000, 4'b0100, "R4");
        probe(32'h12AB_CDEF, 4'b0100, "R4");
        probe(32'h1300_0000, 4'b0000, "R4");
        probe(32'h9200_0000, 4'b0000, "R4");
    endtask

    task automatic t_disable;
        write_slot(2'd2, 16'h12FF, 8'hFF, 1'b0);
        probe(32'h1200_0000, 4'b0000, "R5");
        probe(32'h12AB_CDEF, 4'b0000, "R5");
    endtask

    task automatic t_priority;
        write_slot(2'd0, 16'h0050, 8'h00, 1'b1);
        write_slot(2'd3, 16'h0050, 8'h0F, 1'b1);
        probe(32'h0050_0000, 4'b0001, "R6");
        probe(32'h0051_0000, 4'b1000, "R6");
        probe(32'h005F_FFFF, 4'b1000, "R6");
        write_slot(2'd0, 16'h0050, 8'h00, 1'b0);
        probe(32'h0050_0000, 4'b1000, "R6");
    endtask

    task automatic t_merge_ab;
        write_slot(2'd0, 16'h0100, 8'h01, 1'b1);
        write_slot(2'd1, 16'h0200, 8'h00, 1'b1);
        probe(32'h0200_0000, 4'b0010, "R7");
        write_pair(1'b1, 1'b0);
        probe(32'h0200_0000, 4'b0000, "R7");
        probe(32'h0101_0000, 4'b0001, "R7");
        probe(32'h0050_0000, 4'b1000, "R7");
        write_pair(1'b0, 1'b0);
        probe(32'h0200_0000, 4'b0010, "R10");
    endtask

    task automatic t_merge_cd;
        write_slot(2'd2, 16'h0300, 8'h00, 1'b1);
        write_pair(1'b0, 1'b1);
        probe(32'h0050_0000, 4'b0000, "R8");
        probe(32'h0300_0000, 4'b0100, "R8");
        probe(32'h0200_0000, 4'b0010, "R8");
        write_pair(1'b1, 1'b1);
        probe(32'h0200_0000, 4'b0000, "R7");
        probe(32'h0100_0000, 4'b0001, "R7");
        probe(32'h0300_0000, 4'b0100, "R8");
        probe(32'h0050_0000, 4'b0000, "R8");
        write_pair(1'b0, 1'b0);
        probe(32'h0050_0000, 4'b1000, "R10");
    endtask

    task automatic t_timing;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_slot = 2'd0; cfg_base = 16'h0777; cfg_size = 8'h00; cfg_enable = 1'b1;
        addr = 32'h0777_0000;
        #1;
        check_sel(4'b0000, "R9 before edge");
        @(negedge clk);
        cfg_wr = 1'b0;
        #1;
        check_sel(4'b0001, "R9 after edge");
        probe(32'h0778_0000, 4'b0000, "R9 same-cycle addr");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_exact;
        t_mask;
        t_upper;
        t_disable;
        t_priority;
        t_merge_ab;
        t_merge_cd;
        t_timing;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule